// File: doc/BRIEF.md
# Sleep/Idle Power-Mode Wake Sequencer

This block decides whether the processor core and its peripherals receive a clock. Software issues a power-save command as a one-cycle strobe, and a mode bit sent with it picks one of two low-power states. In Idle only the core clock enable drops and peripherals keep running. In Sleep both enables drop and the active oscillator is considered stopped. The sequencer runs on an always-on reference clock, `clk_i`, so it keeps counting while the gated clocks are off.

The block watches three kinds of wake source: an interrupt request that is enabled and whose priority exceeds the core's current level, a watchdog timeout, and a reset event. Idle returns straight to Run. Sleep first passes through a wait state that holds both clocks off until the oscillator that was in use before Sleep is stable. The stability condition depends on the oscillator kind captured when Sleep was entered: the crystal startup-timer flag, the PLL lock flag, a short fixed cycle count for fast RC or external sources, or a shorter count for a low-power oscillator that kept running. A reset event skips or aborts the wait and returns the block to Run at once.

States are Run (0), Idle (1), Sleep (2) and WakeWait (3). The transitions are:
- Run→Idle and Run→Sleep on a command.
- Idle→Run and Sleep→Run on a wake source. A reset event is the only wake source that takes Sleep→Run directly.
- Sleep→WakeWait on a qualified interrupt or a watchdog timeout.
- WakeWait→Run when the oscillator is stable or a reset event arrives.

Top module: `pmw_sequencer`

## Requirements
- R1: After `rst_ni` is deasserted, `state_o` is 0 (Run), both clock enables are 1 and `wake_o` is 0. In Run, both enables stay 1.
- R2: In Run, a command with `pwrsave_idle_i`=1 moves the block to Idle (1) on the next cycle. In Idle, `cpu_clk_en_o`=0 and `per_clk_en_o`=1.
- R3: In Run, a command with `pwrsave_idle_i`=0 moves the block to Sleep (2) on the next cycle. In Sleep, both enables are 0.
- R4: A command that arrives while the block is in Idle, Sleep or WakeWait has no effect.
- R5: Idle returns to Run on the next cycle on any of these wake sources: a qualified interrupt (`irq_req_i`, `irq_en_i` and `irq_prio_i` > `cpu_lvl_i`), a watchdog timeout, or a reset event. An interrupt that is not enabled, or whose priority is not strictly above `cpu_lvl_i`, does not wake the block.
- R6: Sleep moves to WakeWait (3) on the next cycle on a qualified interrupt or a watchdog timeout, and both enables stay 0 in WakeWait. A reset event moves Sleep directly to Run.
- R7: `wake_o` is 1 for exactly one cycle: the first cycle after the block leaves Idle or Sleep. It is 0 at all other times.
- R8: `osc_kind_i` is captured when Sleep is entered (0 crystal, 1 PLL, 2 fast RC/external, 3 low-power kept running). Changes to it during Sleep or WakeWait have no effect.
- R9: For kind 0, WakeWait holds until `ost_done_i` is 1, and Run follows on the next cycle.
- R10: For kind 1, WakeWait holds until `pll_lock_i` is 1, and Run follows on the next cycle.
- R11: For kind 2, WakeWait lasts exactly FAST_DLY cycles, whatever the values of `ost_done_i` and `pll_lock_i`.
- R12: For kind 3, WakeWait lasts exactly LP_DLY cycles, whatever the values of `ost_done_i` and `pll_lock_i`.
- R13: A reset event during WakeWait returns the block to Run on the next cycle and takes priority over the pending wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| pwrsave_req_i | input | 1 | Power-save command strobe |
| pwrsave_idle_i | input | 1 | Command mode bit: 1 = Idle, 0 = Sleep |
| irq_req_i | input | 1 | Interrupt request |
| irq_en_i | input | 1 | Interrupt enable |
| irq_prio_i | input | PRIO_W | Priority of the requesting interrupt |
| cpu_lvl_i | input | PRIO_W | Current core priority level |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| reset_evt_i | input | 1 | Reset event (power-on, brown-out, pin) |
| osc_kind_i | input | 2 | Kind of oscillator in use |
| ost_done_i | input | 1 | Oscillator startup timer finished |
| pll_lock_i | input | 1 | PLL locked |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| wake_o | output | 1 | One-cycle wake event |
| state_o | output | 2 | Current state: 0 Run, 1 Idle, 2 Sleep, 3 WakeWait |

## Verification
The bench builds the block with FAST_DLY=5, LP_DLY=2 and PRIO_W=3. The short delays make the exact WakeWait length of both counted paths measurable in a few cycles, and make a reset event that lands in the middle of a counted wait a frequent random outcome. A 3-bit priority makes equal, lower and higher interrupt levels all common under random stimulus. Directed sequences hold the startup and lock flags low for long stretches and change the oscillator kind while the block is asleep.

// File: rtl/pmw_pkg.sv
`timescale 1ns/1ps
package pmw_pkg;
    typedef enum logic [1:0] {
        PM_RUN      = 2'd0,
        PM_IDLE     = 2'd1,
        PM_SLEEP    = 2'd2,
        PM_WAKEWAIT = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        OSC_XTAL   = 2'd0,
        OSC_PLL    = 2'd1,
        OSC_FAST   = 2'd2,
        OSC_LPKEEP = 2'd3
    } osc_kind_e;
endpackage

// File: rtl/pmw_wake_qual.sv
`timescale 1ns/1ps
module pmw_wake_qual #(
    parameter int PRIO_W = 3
) (
    input  logic              irq_req_i,
    input  logic              irq_en_i,
    input  logic [PRIO_W-1:0] irq_prio_i,
    input  logic [PRIO_W-1:0] cpu_lvl_i,
    input  logic              wdt_timeout_i,
    input  logic              reset_evt_i,
    output logic              wake_any_o,
    output logic              wake_rst_o
);
    logic irq_ok;

    always_comb begin
        irq_ok     = irq_req_i && irq_en_i && (irq_prio_i > cpu_lvl_i);
        wake_rst_o = reset_evt_i;
        wake_any_o = irq_ok || wdt_timeout_i || reset_evt_i;
    end
endmodule

// File: rtl/pmw_delay_cnt.sv
`timescale 1ns/1ps
module pmw_delay_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pmw_fsm.sv
`timescale 1ns/1ps
module pmw_fsm
    import pmw_pkg::*;
#(
    parameter int FAST_DLY = 10,
    parameter int LP_DLY   = 4,
    parameter int CNT_W    = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             idle_sel_i,
    input  logic             wake_any_i,
    input  logic             wake_rst_i,
    input  logic [1:0]       osc_kind_i,
    input  logic             ost_done_i,
    input  logic             pll_lock_i,
    input  logic             cnt_zero_i,
    output logic             cnt_load_o,
    output logic [CNT_W-1:0] cnt_val_o,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic             wake_o,
    output logic [1:0]       state_o
);
    localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_DLY - 1);
    localparam logic [CNT_W-1:0] LP_LOAD   = CNT_W'(LP_DLY - 1);

    pm_state_e state_q, state_d;
    osc_kind_e osc_q;
    logic      capture;
    logic      wake_q, wake_d;

    // state register, captured oscillator kind and wake pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PM_RUN;
            osc_q   <= OSC_XTAL;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
            if (capture) begin
                osc_q <= osc_kind_e'(osc_kind_i);
            end
        end
    end

    // transitions
    always_comb begin
        state_d    = state_q;
        capture    = 1'b0;
        wake_d     = 1'b0;
        cnt_load_o = 1'b0;
        cnt_val_o  = (osc_q == OSC_FAST) ? FAST_LOAD : LP_LOAD;
        unique case (state_q)
            PM_RUN: begin
                if (req_i) begin
                    state_d = idle_sel_i ? PM_IDLE : PM_SLEEP;
                    capture = !idle_sel_i;
                end
            end
            PM_IDLE: begin
                if (wake_any_i) begin
                    state_d = PM_RUN;
                    wake_d  = 1'b1;
                end
            end
            PM_SLEEP: begin
                if (wake_rst_i) begin
                    state_d = PM_RUN;
                    wake_d  = 1'b1;
                end else if (wake_any_i) begin
                    state_d    = PM_WAKEWAIT;
                    wake_d     = 1'b1;
                    cnt_load_o = 1'b1;
                end
            end
            PM_WAKEWAIT: begin
                if (wake_rst_i) begin
                    state_d = PM_RUN;
                end else begin
                    unique case (osc_q)
                        OSC_XTAL: if (ost_done_i) state_d = PM_RUN;
                        OSC_PLL:  if (pll_lock_i) state_d = PM_RUN;
                        default:  if (cnt_zero_i) state_d = PM_RUN;
                    endcase
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    // outputs
    always_comb begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                cpu_clk_en_o = 1'b1;
                per_clk_en_o = 1'b1;
            end
            PM_IDLE:     per_clk_en_o = 1'b1;
            PM_SLEEP,
            PM_WAKEWAIT: ;
            default: ;
        endcase
        wake_o  = wake_q;
        state_o = state_q;
    end
endmodule

// File: rtl/pmw_sequencer.sv
`timescale 1ns/1ps
module pmw_sequencer #(
    parameter int FAST_DLY = 10,
    parameter int LP_DLY   = 4,
    parameter int PRIO_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwrsave_req_i,
    input  logic              pwrsave_idle_i,
    input  logic              irq_req_i,
    input  logic              irq_en_i,
    input  logic [PRIO_W-1:0] irq_prio_i,
    input  logic [PRIO_W-1:0] cpu_lvl_i,
    input  logic              wdt_timeout_i,
    input  logic              reset_evt_i,
    input  logic [1:0]        osc_kind_i,
    input  logic              ost_done_i,
    input  logic              pll_lock_i,
    output logic              cpu_clk_en_o,
    output logic              per_clk_en_o,
    output logic              wake_o,
    output logic [1:0]        state_o
);
    localparam int MAX_DLY = (FAST_DLY > LP_DLY) ? FAST_DLY : LP_DLY;
    localparam int CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);

    logic             wake_any, wake_rst;
    logic             cnt_load, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    pmw_wake_qual #(.PRIO_W(PRIO_W)) u_qual (
        .irq_req_i     (irq_req_i),
        .irq_en_i      (irq_en_i),
        .irq_prio_i    (irq_prio_i),
        .cpu_lvl_i     (cpu_lvl_i),
        .wdt_timeout_i (wdt_timeout_i),
        .reset_evt_i   (reset_evt_i),
        .wake_any_o    (wake_any),
        .wake_rst_o    (wake_rst)
    );

    pmw_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .zero_o     (cnt_zero)
    );

    pmw_fsm #(.FAST_DLY(FAST_DLY), .LP_DLY(LP_DLY), .CNT_W(CNT_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (pwrsave_req_i),
        .idle_sel_i   (pwrsave_idle_i),
        .wake_any_i   (wake_any),
        .wake_rst_i   (wake_rst),
        .osc_kind_i   (osc_kind_i),
        .ost_done_i   (ost_done_i),
        .pll_lock_i   (pll_lock_i),
        .cnt_zero_i   (cnt_zero),
        .cnt_load_o   (cnt_load),
        .cnt_val_o    (cnt_val),
        .cpu_clk_en_o (cpu_clk_en_o),
        .per_clk_en_o (per_clk_en_o),
        .wake_o       (wake_o),
        .state_o      (state_o)
    );
endmodule

// File: rtl/pmw_sequencer_chk.sv
`timescale 1ns/1ps
module pmw_sequencer_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       reset_evt_i,
    input logic       pwrsave_req_i,
    input logic       cpu_clk_en_o,
    input logic       per_clk_en_o,
    input logic       wake_o,
    input logic [1:0] state_o
);
    assert_run_clocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd0) |-> (cpu_clk_en_o && per_clk_en_o));

    assert_idle_clocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd1) |-> (!cpu_clk_en_o && per_clk_en_o));

    assert_sleep_clocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2) |-> (!cpu_clk_en_o && !per_clk_en_o));

    assert_cmd_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && pwrsave_req_i && !reset_evt_i) |=> (state_o != 2'd1));

    assert_wait_clocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd3) |-> (!cpu_clk_en_o && !per_clk_en_o));

    assert_wait_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd3) |-> ($past(state_o) == 2'd2 || $past(state_o) == 2'd3));

    assert_sleep_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && reset_evt_i) |=> (state_o == 2'd0));

    assert_wake_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> ($past(state_o) == 2'd1 || $past(state_o) == 2'd2));

    assert_wake_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    assert_wait_reset_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd3 && reset_evt_i) |=> (state_o == 2'd0));
endmodule

bind pmw_sequencer pmw_sequencer_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reset_evt_i   (reset_evt_i),
    .pwrsave_req_i (pwrsave_req_i),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .wake_o        (wake_o),
    .state_o       (state_o)
);

// File: tb/test_pmw_sequencer.sv
`timescale 1ns/1ps
module test_pmw_sequencer;
    localparam int FAST_DLY = 5;
    localparam int LP_DLY   = 2;
    localparam int PRIO_W   = 3;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic req = 1'b0, idle_sel = 1'b0, irq_req = 1'b0, irq_en = 1'b0;
    logic [PRIO_W-1:0] irq_prio = '0, cpu_lvl = '0;
    logic wdt = 1'b0, rst_evt = 1'b0, ost = 1'b0, pll = 1'b0;
    logic [1:0] osc = 2'd0;
    logic cpu_en, per_en, wake;
    logic [1:0] state;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    pmw_sequencer #(.FAST_DLY(FAST_DLY), .LP_DLY(LP_DLY), .PRIO_W(PRIO_W)) i_pmw_sequencer (
        .clk_i(clk), .rst_ni(rst_ni), .pwrsave_req_i(req), .pwrsave_idle_i(idle_sel),
        .irq_req_i(irq_req), .irq_en_i(irq_en), .irq_prio_i(irq_prio), .cpu_lvl_i(cpu_lvl),
        .wdt_timeout_i(wdt), .reset_evt_i(rst_evt), .osc_kind_i(osc), .ost_done_i(ost),
        .pll_lock_i(pll), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .wake_o(wake),
        .state_o(state)
    );

    // reference model built from the requirements
    logic [1:0] m_state, m_osc;
    logic       m_wake;
    int         m_left;

    function automatic logic irq_wakes();
        return irq_req && irq_en && (irq_prio > cpu_lvl);
    endfunction

    function automatic logic exp_cpu(input logic [1:0] s);
        return s == 2'd0;
    endfunction

    function automatic logic exp_per(input logic [1:0] s);
        return s <= 2'd1;
    endfunction

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_state <= 2'd0; m_osc <= 2'd0; m_wake <= 1'b0; m_left <= 0;
        end else begin
            m_wake <= 1'b0;
            case (m_state)
                2'd0: if (req) begin
                    m_state <= idle_sel ? 2'd1 : 2'd2;
                    if (!idle_sel) m_osc <= osc;
                end
                2'd1: if (irq_wakes() || wdt || rst_evt) begin
                    m_state <= 2'd0; m_wake <= 1'b1;
                end
                2'd2: if (rst_evt) begin
                    m_state <= 2'd0; m_wake <= 1'b1;
                end else if (irq_wakes() || wdt) begin
                    m_state <= 2'd3; m_wake <= 1'b1;
                    m_left <= (m_osc == 2'd2) ? FAST_DLY : LP_DLY;
                end
                default: begin
                    if (rst_evt) m_state <= 2'd0;
                    else if (m_osc == 2'd0) begin if (ost) m_state <= 2'd0; end
                    else if (m_osc == 2'd1) begin if (pll) m_state <= 2'd0; end
                    else if (m_left <= 1) m_state <= 2'd0;
                    else m_left <= m_left - 1;
                end
            endcase
        end
    end

    task automatic cmp(input string tag);
        nchk++;
        if (state !== m_state || cpu_en !== exp_cpu(m_state) ||
            per_en !== exp_per(m_state) || wake !== m_wake) begin
            nfail++;
            $display("FAIL %s: state=%0d cpu=%b per=%b wake=%b expected state=%0d cpu=%b per=%b wake=%b",
                     tag, state, cpu_en, per_en, wake, m_state, exp_cpu(m_state),
                     exp_per(m_state), m_wake);
        end
    endtask

    task automatic expect_val(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic quiet();
        req = 0; idle_sel = 0; irq_req = 0; irq_en = 0; irq_prio = '0; cpu_lvl = '0;
        wdt = 0; rst_evt = 0; ost = 0; pll = 0;
    endtask

    task automatic go_sleep(input logic [1:0] kind, input string tag);
        req = 1; idle_sel = 0; osc = kind;
        tick(tag);
        req = 0;
    endtask

    task automatic wdt_wake(input string tag);
        wdt = 1;
        tick(tag);
        wdt = 0;
    endtask

    task automatic count_wait(input string tag, output int n);
        n = 0;
        while (state == 2'd3 && n < 100) begin
            tick(tag);
            n++;
        end
    endtask

    initial begin
        #3000000;
        nfail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        quiet();
        repeat (3) @(negedge clk);
        rst_ni = 1;
        @(negedge clk);
        cmp("R1");
        expect_val("R1 state", state, 0);
        expect_val("R1 enables", {cpu_en, per_en}, 3);

        // Idle entry, ignored command, unqualified interrupts, qualified wake
        req = 1; idle_sel = 1; tick("R2"); req = 0;
        expect_val("R2 state", state, 1);
        req = 1; idle_sel = 0; tick("R4"); req = 0;
        expect_val("R4 idle kept", state, 1);
        irq_req = 1; irq_en = 0; irq_prio = 3'd7; cpu_lvl = 3'd0; tick("R5");
        irq_en = 1; irq_prio = 3'd4; cpu_lvl = 3'd4; tick("R5");
        expect_val("R5 equal prio no wake", state, 1);
        irq_prio = 3'd5; tick("R5"); quiet();
        expect_val("R5 woken", state, 0);
        expect_val("R7 pulse", wake, 1);
        tick("R7");
        expect_val("R7 single", wake, 0);

        // Sleep entry and reset-event wake
        go_sleep(2'd0, "R3");
        expect_val("R3 enables", {cpu_en, per_en}, 0);
        req = 1; idle_sel = 1; tick("R4"); req = 0;
        expect_val("R4 sleep kept", state, 2);
        rst_evt = 1; tick("R6"); rst_evt = 0;
        expect_val("R6 reset to run", state, 0);

        // crystal, kind changed during sleep must not matter
        go_sleep(2'd0, "R8");
        osc = 2'd2;
        tick("R8");
        wdt_wake("R6");
        expect_val("R6 wait", state, 3);
        repeat (8) tick("R9");
        expect_val("R8 still waiting", state, 3);
        ost = 1; tick("R9"); ost = 0;
        expect_val("R9 run", state, 0);

        // PLL
        go_sleep(2'd1, "R10");
        irq_req = 1; irq_en = 1; irq_prio = 3'd2; cpu_lvl = 3'd1; tick("R6"); quiet();
        ost = 1;
        repeat (4) tick("R10");
        expect_val("R10 waiting", state, 3);
        pll = 1; tick("R10"); quiet();
        expect_val("R10 run", state, 0);

        // fast fixed delay
        go_sleep(2'd2, "R11");
        wdt_wake("R11");
        count_wait("R11", n);
        expect_val("R11 length", n, FAST_DLY);

        // low-power kept running, flags low
        go_sleep(2'd3, "R12");
        wdt_wake("R12");
        count_wait("R12", n);
        expect_val("R12 length", n, LP_DLY);

        // reset event aborts a pending wait
        go_sleep(2'd2, "R13");
        wdt_wake("R13");
        tick("R13");
        rst_evt = 1; tick("R13"); rst_evt = 0;
        expect_val("R13 run", state, 0);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            req      = ($urandom_range(0, 5) == 0);
            idle_sel = $urandom_range(0, 1);
            irq_req  = ($urandom_range(0, 6) == 0);
            irq_en   = $urandom_range(0, 1);
            irq_prio = PRIO_W'($urandom_range(0, 7));
            cpu_lvl  = PRIO_W'($urandom_range(0, 7));
            wdt      = ($urandom_range(0, 19) == 0);
            rst_evt  = ($urandom_range(0, 39) == 0);
            osc      = 2'($urandom_range(0, 3));
            ost      = ($urandom_range(0, 4) == 0);
            pll      = ($urandom_range(0, 4) == 0);
            tick("RND");
        end
        quiet();

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule